// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash and turns the stream of bus-write cycles into one-cycle start requests for an erase/program controller. Each write carries an address and a data word, and only the low eleven address bits and the low data byte take part in the decoding. Multi-write unlock sequences select program, chip erase, block erase (with a selection window for further blocks), erase suspend, erase resume, auto-select and an unlock-bypass mode in which programming takes two writes. Any write that breaks an expected sequence drops the decoder back to plain read mode in its current context.

The controller reports `ctl_busy` while an operation runs and `ctl_err` when the operation ends badly. The decoder samples `ctl_err` on the cycle in which `ctl_busy` falls. Depending on the state, it either ignores writes, filters them, or holds the status view until a reset command arrives. The outputs `mode_o`, `byp_o` and `sus_o` tell the read path whether to return array data, identification data or status.

States: `ST_IDLE` (read mode of the current context: normal, bypass or suspended), `ST_AUTO` (auto-select), `ST_UNL1`/`ST_UNL2` (first and second unlock write seen), `ST_PADDR` (waiting for the program address/data), `ST_ERS1`/`ST_ERS2`/`ST_ERS3` (erase prefix 80h, second unlock pair), `ST_BLKW` (block selection window open), `ST_BERASE` (block erase running or resumed), `ST_RUN` (program or chip erase running), `ST_ERR` (error held), `ST_BYPX` (first write of the bypass exit). Transitions:
- Unlock progress: IDLE→UNL1→UNL2.
- Command dispatch from UNL2: to AUTO, PADDR, ERS1, or IDLE with bypass.
- Program: PADDR→RUN.
- Erase prefix: ERS1→ERS2→ERS3, then ERS3→RUN for chip erase or ERS3→BLKW for block erase.
- Window: BLKW→BERASE on expiry, or BLKW→IDLE(suspended) on suspend.
- Running block erase: BERASE→IDLE on suspend or abort.
- Resume: IDLE(suspended)→BERASE.
- Completion: RUN/BERASE→IDLE, or →ERR when an error is reported.
- Error clear: ERR→IDLE.
- Bypass exit: IDLE(bypass)→BYPX→IDLE.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `mode_o` is 0 (array), `byp_o` and `sus_o` are 0 and every start pulse is low. Mode encoding: 0 array, 1 auto-select, 2 status.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, then any address/data, give a one-cycle `pgm_go`. The pulse appears in the cycle after the fourth write, with `pgm_addr`/`pgm_data` holding that write, and `mode_o` becomes 2.
- R3: Only address bits 10..0 and data bits 7..0 are compared. Higher address and data bits do not affect decoding.
- R4: A write that breaks an unlock sequence returns the decoder to read mode (`mode_o`=0) and produces no pulse.
- R5: The unlock pair followed by 90h@555h enters auto-select (`mode_o`=1). The mode persists until the next command.
- R6: Read/reset is accepted as a single F0h at any address or as the unlock pair then F0h. Either form returns to read mode.
- R7: While a program or chip erase runs, every write is ignored. When `ctl_busy` falls without error the decoder returns to read mode.
- R8: The unlock pair, 80h@555h, the unlock pair, then 10h@555h gives a one-cycle `chip_ers_go`. At most one start pulse is high in any cycle.
- R9: The same prefix with 30h at a block address gives `blk_mark` with `blk_addr`. Each further 30h inside the window marks another block and restarts the window. `blk_ers_go` rises WIN_CYCLES cycles after the last marking write was taken.
- R10: During a running block erase only B0h (`sus_go`, suspended, `mode_o`=0) and F0h (`abort_go`, read mode) are accepted. Other writes are ignored.
- R11: In suspend, 30h gives `res_go` and the running view (`mode_o`=2, `sus_o`=0). Auto-select entered in suspend and then reset returns to suspend, not to read mode.
- R12: B0h while the selection window is open suspends at once with no `sus_go`. The following 30h gives `blk_ers_go` instead of `res_go`, and no further blocks are accepted.
- R13: If `ctl_err` is high when `ctl_busy` falls, `mode_o` stays 2 and all writes except F0h are ignored. F0h returns to read mode.
- R14: Unlock pair then 20h@555h enters bypass (`byp_o`=1). There, A0h then address/data programs, 90h then 00h leaves bypass, and other writes are ignored. A reset after a bypass program error stays in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle bus-write strobe |
| cmd_addr | input | ADDR_W | Write address |
| cmd_data | input | DATA_W | Write data |
| ctl_busy | input | 1 | Controller operation running |
| ctl_err | input | 1 | Controller error, sampled when busy falls |
| pgm_go | output | 1 | Program start pulse |
| pgm_addr | output | ADDR_W | Captured program address |
| pgm_data | output | DATA_W | Captured program data |
| chip_ers_go | output | 1 | Chip erase start pulse |
| blk_mark | output | 1 | Block added to the erase list |
| blk_addr | output | ADDR_W | Address of the added block |
| blk_ers_go | output | 1 | Block erase start pulse |
| sus_go | output | 1 | Erase suspend request pulse |
| res_go | output | 1 | Erase resume request pulse |
| abort_go | output | 1 | Block erase abort pulse |
| mode_o | output | 2 | Read view: 0 array, 1 auto-select, 2 status |
| byp_o | output | 1 | Unlock-bypass mode active |
| sus_o | output | 1 | Erase suspended |

## Verification
The hardest situation to reach is a suspend issued while the block selection window is still open, followed by a resume that must start the erase rather than resume it. The bench reaches it with the six erase writes and then, on the very next cycle, B0h, well before a short window (8 cycles) can expire. It then checks that no suspend pulse was raised and that the resume write produces the erase start. A second hard corner is the nested context of auto-select entered from suspend. The bench reaches it by suspending a running erase, unlocking into auto-select, and resetting before it resumes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMP_AW = 11;

    localparam logic [CMP_AW-1:0] UNL_ADDR_A = 11'h555;
    localparam logic [CMP_AW-1:0] UNL_ADDR_B = 11'h2AA;

    // index of each recognised data byte in the hit vector
    localparam int K_AA  = 0;
    localparam int K_55  = 1;
    localparam int K_F0  = 2;
    localparam int K_90  = 3;
    localparam int K_A0  = 4;
    localparam int K_20  = 5;
    localparam int K_80  = 6;
    localparam int K_10  = 7;
    localparam int K_30  = 8;
    localparam int K_B0  = 9;
    localparam int K_00  = 10;
    localparam int NCODE = 11;

    function automatic logic [7:0] code_val(input int idx);
        case (idx)
            K_AA:    return 8'hAA;
            K_55:    return 8'h55;
            K_F0:    return 8'hF0;
            K_90:    return 8'h90;
            K_A0:    return 8'hA0;
            K_20:    return 8'h20;
            K_80:    return 8'h80;
            K_10:    return 8'h10;
            K_30:    return 8'h30;
            K_B0:    return 8'hB0;
            default: return 8'h00;
        endcase
    endfunction

    typedef enum logic [3:0] {
        ST_IDLE, ST_AUTO, ST_UNL1, ST_UNL2, ST_PADDR,
        ST_ERS1, ST_ERS2, ST_ERS3, ST_BLKW, ST_BERASE,
        ST_RUN, ST_ERR, ST_BYPX
    } fst_e;

    typedef enum logic [1:0] {
        CTX_READ = 2'd0,
        CTX_BYP  = 2'd1,
        CTX_SUSP = 2'd2
    } ctx_e;

    localparam logic [1:0] MODE_ARRAY  = 2'd0;
    localparam logic [1:0] MODE_AUTO   = 2'd1;
    localparam logic [1:0] MODE_STATUS = 2'd2;

    function automatic logic [1:0] mode_of(input fst_e s);
        case (s)
            ST_AUTO:                             return MODE_AUTO;
            ST_RUN, ST_BLKW, ST_BERASE, ST_ERR:  return MODE_STATUS;
            default:                             return MODE_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
(
    input  logic [CMP_AW-1:0] a_lo,
    input  logic [7:0]        d_lo,
    output logic              at_a,
    output logic              at_b,
    output logic [NCODE-1:0]  hit
);

    assign at_a = (a_lo == UNL_ADDR_A);
    assign at_b = (a_lo == UNL_ADDR_B);

    for (genvar i = 0; i < NCODE; i++) begin : g_code
        assign hit[i] = (d_lo == code_val(i));
    end

endmodule

// File: rtl/flash_win_timer.sv
module flash_win_timer #(
    parameter int WIN_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);

    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && !restart && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int WIN_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              ctl_busy,
    input  logic              ctl_err,
    output logic              pgm_go,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              chip_ers_go,
    output logic              blk_mark,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              blk_ers_go,
    output logic              sus_go,
    output logic              res_go,
    output logic              abort_go,
    output logic [1:0]        mode_o,
    output logic              byp_o,
    output logic              sus_o
);

    fst_e st_q, nxt_st;
    ctx_e ctx_q, nxt_ctx;
    logic pend_q, nxt_pend;
    logic busy_q, busy_fall;
    logic at_a, at_b;
    logic [NCODE-1:0] hit;
    logic tmr_done;
    logic g_pgm, g_cers, g_mark, g_bers, g_sus, g_res, g_abort;

    flash_cmd_match u_match (
        .a_lo (cmd_addr[CMP_AW-1:0]),
        .d_lo (cmd_data[7:0]),
        .at_a (at_a),
        .at_b (at_b),
        .hit  (hit)
    );

    flash_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_BLKW),
        .restart (cmd_wr),
        .done    (tmr_done)
    );

    assign busy_fall = busy_q && !ctl_busy;

    // next state and start decisions
    always_comb begin
        nxt_st   = st_q;
        nxt_ctx  = ctx_q;
        nxt_pend = pend_q;
        g_pgm = 1'b0; g_cers = 1'b0; g_mark = 1'b0; g_bers = 1'b0;
        g_sus = 1'b0; g_res = 1'b0; g_abort = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_AUTO: begin
                if (cmd_wr) begin
                    if (st_q == ST_IDLE && ctx_q == CTX_BYP) begin
                        if (hit[K_A0])      nxt_st = ST_PADDR;
                        else if (hit[K_90]) nxt_st = ST_BYPX;
                    end else if (hit[K_F0]) begin
                        nxt_st = ST_IDLE;
                    end else if (hit[K_AA] && at_a) begin
                        nxt_st = ST_UNL1;
                    end else if (st_q == ST_IDLE && ctx_q == CTX_SUSP && hit[K_30]) begin
                        nxt_st   = ST_BERASE;
                        nxt_ctx  = CTX_READ;
                        nxt_pend = 1'b0;
                        if (pend_q) g_bers = 1'b1;
                        else        g_res  = 1'b1;
                    end else begin
                        nxt_st = ST_IDLE;
                    end
                end
            end
            ST_UNL1: begin
                if (cmd_wr) nxt_st = (hit[K_55] && at_b) ? ST_UNL2 : ST_IDLE;
            end
            ST_UNL2: begin
                if (cmd_wr) begin
                    nxt_st = ST_IDLE;
                    if (at_a && hit[K_90]) begin
                        nxt_st = ST_AUTO;
                    end else if (at_a && hit[K_A0]) begin
                        nxt_st = ST_PADDR;
                    end else if (at_a && hit[K_20] && ctx_q == CTX_READ) begin
                        nxt_ctx = CTX_BYP;
                    end else if (at_a && hit[K_80] && ctx_q == CTX_READ) begin
                        nxt_st = ST_ERS1;
                    end
                end
            end
            ST_PADDR: begin
                if (cmd_wr) begin
                    g_pgm  = 1'b1;
                    nxt_st = ST_RUN;
                end
            end
            ST_ERS1: begin
                if (cmd_wr) nxt_st = (hit[K_AA] && at_a) ? ST_ERS2 : ST_IDLE;
            end
            ST_ERS2: begin
                if (cmd_wr) nxt_st = (hit[K_55] && at_b) ? ST_ERS3 : ST_IDLE;
            end
            ST_ERS3: begin
                if (cmd_wr) begin
                    if (hit[K_10] && at_a) begin
                        g_cers = 1'b1;
                        nxt_st = ST_RUN;
                    end else if (hit[K_30]) begin
                        g_mark = 1'b1;
                        nxt_st = ST_BLKW;
                    end else begin
                        nxt_st = ST_IDLE;
                    end
                end
            end
            ST_BLKW: begin
                if (cmd_wr) begin
                    if (hit[K_30]) begin
                        g_mark = 1'b1;
                    end else if (hit[K_B0]) begin
                        nxt_st   = ST_IDLE;
                        nxt_ctx  = CTX_SUSP;
                        nxt_pend = 1'b1;
                    end else begin
                        nxt_st = ST_IDLE;
                    end
                end else if (tmr_done) begin
                    g_bers = 1'b1;
                    nxt_st = ST_BERASE;
                end
            end
            ST_BERASE: begin
                if (busy_fall) begin
                    nxt_st = ctl_err ? ST_ERR : ST_IDLE;
                end else if (cmd_wr && hit[K_B0]) begin
                    g_sus   = 1'b1;
                    nxt_st  = ST_IDLE;
                    nxt_ctx = CTX_SUSP;
                end else if (cmd_wr && hit[K_F0]) begin
                    g_abort = 1'b1;
                    nxt_st  = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (busy_fall) nxt_st = ctl_err ? ST_ERR : ST_IDLE;
            end
            ST_ERR: begin
                if (cmd_wr && hit[K_F0]) nxt_st = ST_IDLE;
            end
            ST_BYPX: begin
                if (cmd_wr) begin
                    nxt_st = ST_IDLE;
                    if (hit[K_00]) nxt_ctx = CTX_READ;
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ctx_q  <= CTX_READ;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            st_q   <= nxt_st;
            ctx_q  <= nxt_ctx;
            pend_q <= nxt_pend;
            busy_q <= ctl_busy;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_go      <= 1'b0;
            pgm_addr    <= '0;
            pgm_data    <= '0;
            chip_ers_go <= 1'b0;
            blk_mark    <= 1'b0;
            blk_addr    <= '0;
            blk_ers_go  <= 1'b0;
            sus_go      <= 1'b0;
            res_go      <= 1'b0;
            abort_go    <= 1'b0;
            mode_o      <= MODE_ARRAY;
            byp_o       <= 1'b0;
            sus_o       <= 1'b0;
        end else begin
            pgm_go      <= g_pgm;
            chip_ers_go <= g_cers;
            blk_mark    <= g_mark;
            blk_ers_go  <= g_bers;
            sus_go      <= g_sus;
            res_go      <= g_res;
            abort_go    <= g_abort;
            if (g_pgm) begin
                pgm_addr <= cmd_addr;
                pgm_data <= cmd_data;
            end
            if (g_mark) blk_addr <= cmd_addr;
            mode_o <= mode_of(nxt_st);
            byp_o  <= (nxt_ctx == CTX_BYP);
            sus_o  <= (nxt_ctx == CTX_SUSP);
        end
    end

    // R7
    run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !busy_fall) |=>
            !(pgm_go || chip_ers_go || blk_mark || blk_ers_go || sus_go || res_go || abort_go)
            && mode_o == MODE_STATUS);

    // R8
    go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_go, chip_ers_go, blk_ers_go, sus_go, res_go, abort_go}));

    // R9
    mark_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WIN_CYCLES > 2 && blk_mark) |=> !blk_ers_go);

    // R10
    ers_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BERASE && cmd_wr && !hit[K_B0] && !hit[K_F0] && !busy_fall)
            |=> st_q == ST_BERASE);

    // R13
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERR && !(cmd_wr && hit[K_F0])) |=> mode_o == MODE_STATUS);

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    localparam int AW  = 18;
    localparam int DW  = 16;
    localparam int WIN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          ctl_busy = 1'b0;
    logic          ctl_err = 1'b0;
    logic          pgm_go, chip_ers_go, blk_mark, blk_ers_go, sus_go, res_go, abort_go;
    logic [AW-1:0] pgm_addr, blk_addr;
    logic [DW-1:0] pgm_data;
    logic [1:0]    mode_o;
    logic          byp_o, sus_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .WIN_CYCLES(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .ctl_busy(ctl_busy), .ctl_err(ctl_err),
        .pgm_go(pgm_go), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_ers_go(chip_ers_go), .blk_mark(blk_mark), .blk_addr(blk_addr),
        .blk_ers_go(blk_ers_go), .sus_go(sus_go), .res_go(res_go),
        .abort_go(abort_go), .mode_o(mode_o), .byp_o(byp_o), .sus_o(sus_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write, taken at the next rising edge; returns on the following falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_addr = a;
        cmd_data = d;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(18'h00555, 16'h00AA);
        wr(18'h002AA, 16'h0055);
    endtask

    task automatic finish_op(input logic with_err);
        ctl_busy = 1'b0;
        ctl_err  = with_err;
        idle(1);
        ctl_err  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 byp", byp_o, 0);
        chk("R1 sus", sus_o, 0);
        chk("R1 pulses", {pgm_go, chip_ers_go, blk_mark, blk_ers_go, sus_go, res_go, abort_go}, 0);
    endtask

    task automatic t_program();
        unlock();
        wr(18'h00555, 16'h00A0);
        chk("R2 no early go", pgm_go, 0);
        wr(18'h01234, 16'hABCD);
        chk("R2 pgm_go", pgm_go, 1);
        chk("R2 pgm_addr", pgm_addr, 32'h01234);
        chk("R2 pgm_data", pgm_data, 32'hABCD);
        chk("R2 mode status", mode_o, 2);
        idle(1);
        chk("R2 one cycle", pgm_go, 0);
        ctl_busy = 1'b1;
        unlock();
        wr(18'h00555, 16'h00A0);
        wr(18'h00100, 16'h1111);
        chk("R7 ignored while running", pgm_go, 0);
        wr(18'h00000, 16'h00F0);
        chk("R7 reset ignored while running", mode_o, 2);
        finish_op(1'b0);
        chk("R7 back to read", mode_o, 0);
    endtask

    task automatic t_masked();
        wr(18'h3FD55, 16'hFFAA);
        wr(18'h3FAAA, 16'hC355);
        wr(18'h2E555, 16'h12A0);
        wr(18'h3FFFF, 16'h0F0F);
        chk("R3 upper bits ignored", pgm_go, 1);
        chk("R3 full addr captured", pgm_addr, 32'h3FFFF);
        ctl_busy = 1'b1;
        idle(2);
        finish_op(1'b0);
        wr(18'h00D55, 16'h00AA);
        wr(18'h002AA, 16'h0055);
        wr(18'h00555, 16'h0090);
        chk("R3 bit 11 not compared", mode_o, 1);
        wr(18'h00000, 16'h00F0);
    endtask

    task automatic t_broken();
        wr(18'h00555, 16'h00AA);
        wr(18'h002AA, 16'h0012);
        chk("R4 broken mode", mode_o, 0);
        wr(18'h002AA, 16'h0055);
        wr(18'h00555, 16'h0090);
        chk("R4 stale prefix rejected", mode_o, 0);
        unlock();
        wr(18'h00556, 16'h00A0);
        wr(18'h00010, 16'h0001);
        chk("R4 wrong third address", pgm_go, 0);
        chk("R4 still read", mode_o, 0);
    endtask

    task automatic t_autosel();
        unlock();
        wr(18'h00555, 16'h0090);
        chk("R5 auto-select", mode_o, 1);
        idle(3);
        chk("R5 persists", mode_o, 1);
        wr(18'h12345, 16'h00F0);
        chk("R6 single reset", mode_o, 0);
        unlock();
        wr(18'h00555, 16'h0090);
        unlock();
        chk("R5 mid unlock", mode_o, 0);
        wr(18'h00777, 16'h00F0);
        chk("R6 long reset", mode_o, 0);
    endtask

    task automatic t_chip();
        unlock();
        wr(18'h00555, 16'h0080);
        unlock();
        wr(18'h00555, 16'h0010);
        chk("R8 chip_ers_go", chip_ers_go, 1);
        chk("R8 exclusive", {pgm_go, blk_ers_go, sus_go, res_go, abort_go}, 0);
        chk("R8 status", mode_o, 2);
        ctl_busy = 1'b1;
        wr(18'h00000, 16'h00B0);
        chk("R7 suspend ignored on chip erase", sus_go, 0);
        finish_op(1'b0);
        chk("R7 chip erase done", mode_o, 0);
    endtask

    task automatic t_block();
        unlock();
        wr(18'h00555, 16'h0080);
        unlock();
        wr(18'h10000, 16'h0030);
        chk("R9 first mark", blk_mark, 1);
        chk("R9 first addr", blk_addr, 32'h10000);
        chk("R9 status", mode_o, 2);
        idle(3);
        wr(18'h20000, 16'h0030);
        chk("R9 second mark", blk_mark, 1);
        chk("R9 second addr", blk_addr, 32'h20000);
        idle(WIN - 1);
        chk("R9 window still open", blk_ers_go, 0);
        idle(1);
        chk("R9 erase start", blk_ers_go, 1);
        ctl_busy = 1'b1;
        wr(18'h30000, 16'h0030);
        chk("R10 no mark after start", blk_mark, 0);
        wr(18'h00555, 16'h00AA);
        chk("R10 other write ignored", mode_o, 2);
        wr(18'h00000, 16'h00B0);
        chk("R10 sus_go", sus_go, 1);
        chk("R10 suspended", sus_o, 1);
        chk("R10 array view", mode_o, 0);
        ctl_busy = 1'b0;
        unlock();
        wr(18'h00555, 16'h0090);
        chk("R11 auto-select in suspend", mode_o, 1);
        wr(18'h00000, 16'h00F0);
        chk("R11 back to suspend", sus_o, 1);
        chk("R11 array view", mode_o, 0);
        wr(18'h00000, 16'h0030);
        ctl_busy = 1'b1;
        chk("R11 res_go", res_go, 1);
        chk("R11 not suspended", sus_o, 0);
        chk("R11 status", mode_o, 2);
        wr(18'h00000, 16'h00F0);
        chk("R10 abort_go", abort_go, 1);
        chk("R10 abort to read", mode_o, 0);
        finish_op(1'b0);
    endtask

    task automatic t_winsus();
        unlock();
        wr(18'h00555, 16'h0080);
        unlock();
        wr(18'h08000, 16'h0030);
        wr(18'h00000, 16'h00B0);
        chk("R12 no sus_go", sus_go, 0);
        chk("R12 suspended", sus_o, 1);
        idle(WIN + 2);
        chk("R12 no start while suspended", blk_ers_go, 0);
        wr(18'h00000, 16'h0030);
        chk("R12 start on resume", blk_ers_go, 1);
        chk("R12 no res_go", res_go, 0);
        ctl_busy = 1'b1;
        wr(18'h0C000, 16'h0030);
        chk("R12 no more blocks", blk_mark, 0);
        finish_op(1'b0);
        chk("R12 done", mode_o, 0);
    endtask

    task automatic t_error();
        unlock();
        wr(18'h00555, 16'h00A0);
        wr(18'h00042, 16'h0000);
        ctl_busy = 1'b1;
        idle(2);
        finish_op(1'b1);
        chk("R13 error held", mode_o, 2);
        unlock();
        wr(18'h00555, 16'h0090);
        chk("R13 commands ignored", mode_o, 2);
        wr(18'h00000, 16'h00F0);
        chk("R13 cleared", mode_o, 0);
    endtask

    task automatic t_bypass();
        unlock();
        wr(18'h00555, 16'h0020);
        chk("R14 bypass on", byp_o, 1);
        chk("R14 array view", mode_o, 0);
        unlock();
        wr(18'h00555, 16'h0080);
        unlock();
        wr(18'h00555, 16'h0010);
        chk("R14 erase ignored", chip_ers_go, 0);
        chk("R14 still bypass", byp_o, 1);
        wr(18'h00000, 16'h00A0);
        wr(18'h00777, 16'h5A5A);
        chk("R14 bypass pgm_go", pgm_go, 1);
        chk("R14 bypass data", pgm_data, 32'h5A5A);
        ctl_busy = 1'b1;
        idle(2);
        finish_op(1'b1);
        chk("R14 error status", mode_o, 2);
        wr(18'h00000, 16'h00F0);
        chk("R14 reset keeps bypass", byp_o, 1);
        chk("R14 read view", mode_o, 0);
        wr(18'h00000, 16'h0090);
        wr(18'h00000, 16'h0000);
        chk("R14 bypass off", byp_o, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_program();
        t_masked();
        t_broken();
        t_autosel();
        t_chip();
        t_block();
        t_winsus();
        t_error();
        t_bypass();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule